// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block counts hardware events for performance analysis. It has two 32-bit counters. Each cycle, a vector of 64 event pulses comes in. Each counter picks one of those pulses through its own 6-bit select field in a shared control register. A counter advances only while the count-enable bit for the current privilege context (user, supervisor or hypervisor) is set. Those enable bits are common to both counters.

Software reaches the block through a plain register port. Address 0 is the control register. Address 1 is a 64-bit view that holds both counters side by side. Writes take effect at the clock edge. Reads are combinational on the addressed register, with no handshake and no back-pressure: the port accepts a write in every cycle that `reg_wr` is high.

To take a sample every N events, software loads a counter with the two's complement of N. When that counter steps from all ones to zero, it sets a sticky flag. The level interrupt is high while any flag is set and the interrupt enable is on. To take a counter out of use, software selects its park code: 0x1C for the upper counter, 0x14 for the lower counter. A counter on its park code never advances.

Top module: `dual_pmu`

## Requirements
- R1: After reset, the control register reads 0, both counters read 0 and `irq` is low.
- R2: The counter view at address 1 places the upper counter in bits 63:32 and the lower counter in bits 31:0. A write to address 1 replaces both counters in the same edge.
- R3: When a counter steps from 0xFFFFFFFF to 0, its sticky flag is set. The upper counter's flag is control bit 17 and the lower counter's flag is control bit 18.
- R4: The upper counter's select field is control bits 16:11 and the lower counter's is bits 9:4. In each qualified cycle where `evt_pulse[select]` is high, the counter advances by exactly one.
- R5: `ctx` encodes 0 as user, 1 as supervisor, 2 as hypervisor and 3 as none. Control bits 1, 2 and 3 enable counting in user, supervisor and hypervisor context respectively. These bits apply to both counters, and with `ctx`=3 nothing counts.
- R6: Control bit 0 is the interrupt enable. `irq` equals bit 0 ANDed with the OR of the two flags.
- R7: A counter whose select equals its own park code (upper 0x1C, lower 0x14) never advances, even while that pulse is high. The other counter's park code counts normally.
- R8: When a counter write and a qualified event fall in the same cycle, the written value is kept and the event is lost.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set. Bits 16:0 except bit 10 read back as written. Bit 10 and bits 63:19 read 0.
- R10: After a counter is loaded with the two's complement of N, `irq` (with the enable on) rises after exactly N counted events and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 64 | One pulse per event source per cycle |
| ctx | input | 2 | Current privilege context (0 user, 1 supervisor, 2 hypervisor, 3 none) |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 1 | 0 selects control, 1 selects the counter pair |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the addressed register |
| irq | output | 1 | Level overflow interrupt |

## Verification
Each fault in the block's state shows at the ports within one cycle.
- A wrong select decode or context qualification makes the counter view drift by one per affected cycle, which the read after each stimulus window exposes.
- A flag that fails to set, clear or hold shows on `irq` and in control bits 18:17 one cycle after the edge that should have changed it.
- A lost write priority leaves the counter view one count off the written value on the very next read.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CNT_W   = 32;
  localparam int SEL_W   = 6;
  localparam int NUM_EVT = 1 << SEL_W;
  localparam int REG_W   = 2 * CNT_W;

  // control register layout
  localparam int IE_BIT     = 0;
  localparam int EN_USR_BIT = 1;
  localparam int EN_SUP_BIT = 2;
  localparam int EN_HYP_BIT = 3;
  localparam int LO_SEL_LSB = 4;
  localparam int HI_SEL_LSB = 11;
  localparam int CFG_W      = HI_SEL_LSB + SEL_W;   // bits below the flags
  localparam int FLAG_HI    = CFG_W;               // 17
  localparam int FLAG_LO    = CFG_W + 1;           // 18
  localparam int CTRL_W     = FLAG_LO + 1;

  localparam logic [SEL_W-1:0] PARK_HI = 6'h1C;
  localparam logic [SEL_W-1:0] PARK_LO = 6'h14;

  typedef enum logic [1:0] {
    CTX_USER = 2'd0,
    CTX_SUP  = 2'd1,
    CTX_HYP  = 2'd2,
    CTX_NONE = 2'd3
  } ctx_e;
endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic [1:0]        wrap,      // [1] upper, [0] lower
  output logic              ie,
  output logic [2:0]        ctx_en,    // {hyp, sup, usr}
  output logic [SEL_W-1:0]  sel_hi,
  output logic [SEL_W-1:0]  sel_lo,
  output logic [1:0]        flags,     // [1] upper, [0] lower
  output logic [REG_W-1:0]  rdata
);
  localparam int GAP_BIT = LO_SEL_LSB + SEL_W;
  localparam logic [CFG_W-1:0] CFG_MASK = ~(CFG_W'(1) << GAP_BIT);

  logic [CFG_W-1:0] cfg_q;
  logic [1:0]       flag_q;
  logic [1:0]       clr;

  assign clr[1] = wr_en & wdata[FLAG_HI];
  assign clr[0] = wr_en & wdata[FLAG_LO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en) cfg_q <= wdata[CFG_W-1:0] & CFG_MASK;
      // a wrap in the same cycle outranks a clear
      flag_q <= wrap | (flag_q & ~clr);
    end
  end

  assign ie     = cfg_q[IE_BIT];
  assign ctx_en = {cfg_q[EN_HYP_BIT], cfg_q[EN_SUP_BIT], cfg_q[EN_USR_BIT]};
  assign sel_hi = cfg_q[HI_SEL_LSB +: SEL_W];
  assign sel_lo = cfg_q[LO_SEL_LSB +: SEL_W];
  assign flags  = flag_q;
  assign rdata  = {{(REG_W-CTRL_W){1'b0}}, flag_q[0], flag_q[1], cfg_q};
endmodule

// File: rtl/pmu_ctx_qual.sv
module pmu_ctx_qual
  import pmu_pkg::*;
(
  input  logic [1:0] ctx,
  input  logic [2:0] ctx_en,   // {hyp, sup, usr}
  output logic       ok
);
  always_comb begin
    unique case (ctx_e'(ctx))
      CTX_USER: ok = ctx_en[0];
      CTX_SUP:  ok = ctx_en[1];
      CTX_HYP:  ok = ctx_en[2];
      default:  ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 6,
  parameter logic [SEL_W-1:0] PARK = '0,
  localparam int NUM_EVT = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               ok,
  input  logic               wr_en,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   cnt,
  output logic               wrap
);
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit  = ok & evt[sel] & (sel != PARK);
  assign wrap = hit & ~wr_en & (&cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_en) cnt_q <= wdata;
    else if (hit)   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dual_pmu.sv
module dual_pmu
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [1:0]         ctx,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               irq
);
  logic              ie_bit;
  logic [2:0]        ctx_en;
  logic [SEL_W-1:0]  sel [2];
  logic [1:0]        flags;
  logic [1:0]        wrap;
  logic [CNT_W-1:0]  cnt [2];
  logic [REG_W-1:0]  ctrl_rdata;
  logic              ctx_ok;
  logic              ctrl_wr, cnt_wr;

  assign ctrl_wr = reg_wr & ~reg_addr;
  assign cnt_wr  = reg_wr &  reg_addr;

  pmu_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wdata  (reg_wdata[CTRL_W-1:0]),
    .wrap   (wrap),
    .ie     (ie_bit),
    .ctx_en (ctx_en),
    .sel_hi (sel[1]),
    .sel_lo (sel[0]),
    .flags  (flags),
    .rdata  (ctrl_rdata)
  );

  pmu_ctx_qual u_qual (
    .ctx    (ctx),
    .ctx_en (ctx_en),
    .ok     (ctx_ok)
  );

  // index 1 = upper half, index 0 = lower half
  for (genvar g = 0; g < 2; g++) begin : g_cnt
    pmu_counter #(
      .CNT_W (CNT_W),
      .SEL_W (SEL_W),
      .PARK  ((g == 1) ? PARK_HI : PARK_LO)
    ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel[g]),
      .evt   (evt_pulse),
      .ok    (ctx_ok),
      .wr_en (cnt_wr),
      .wdata (reg_wdata[g*CNT_W +: CNT_W]),
      .cnt   (cnt[g]),
      .wrap  (wrap[g])
    );
  end

  assign reg_rdata = reg_addr ? {cnt[1], cnt[0]} : ctrl_rdata;
  assign irq       = ie_bit & (|flags);
endmodule

// File: rtl/dual_pmu_checker.sv
module dual_pmu_checker
  import pmu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        ctx,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              irq,
  input logic              ie_bit,
  input logic [1:0]        flags,
  input logic [SEL_W-1:0]  sel_hi,
  input logic [SEL_W-1:0]  sel_lo,
  input logic [CNT_W-1:0]  cnt_hi,
  input logic [CNT_W-1:0]  cnt_lo
);
  logic wr_c;
  assign wr_c = reg_wr & reg_addr;

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_bit |-> !irq);

  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hi == '1 && !wr_c) |=> (cnt_hi != '0 || flags[1]));

  assert_park_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi == PARK_HI && !wr_c) |=> cnt_hi == $past(cnt_hi));

  assert_park_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lo == PARK_LO && !wr_c) |=> cnt_lo == $past(cnt_lo));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c |=> {cnt_hi, cnt_lo} == $past(reg_wdata));

  assert_no_ctx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx == 2'd3 && !wr_c) |=> $stable({cnt_hi, cnt_lo}));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c |=> (cnt_lo == $past(cnt_lo) || cnt_lo == $past(cnt_lo) + CNT_W'(1)));
endmodule

bind dual_pmu dual_pmu_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctx       (ctx),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .ie_bit    (ie_bit),
  .flags     (flags),
  .sel_hi    (sel[1]),
  .sel_lo    (sel[0]),
  .cnt_hi    (cnt[1]),
  .cnt_lo    (cnt[0])
);

// File: tb/dual_pmu_test.sv
module dual_pmu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] evt_pulse;
  logic [1:0]  ctx;
  logic        reg_wr;
  logic        reg_addr;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;   // 125 MHz

  dual_pmu uut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .ctx(ctx),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        u, s, h;
    logic [5:0]  up, lo;
    logic [31:0] pre_hi, pre_lo;
    logic [1:0]  cx;
    logic [63:0] mask;
    logic [3:0]  n;
    logic [31:0] exp_hi, exp_lo;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0, 6'h03,6'h05, 32'd0,  32'd0,   2'd0, 64'h8,        4'd4, 32'd4,   32'd0  },
    '{1'b1,1'b0,1'b0, 6'h03,6'h05, 32'd10, 32'd20,  2'd0, 64'h28,       4'd3, 32'd13,  32'd23 },
    '{1'b1,1'b0,1'b0, 6'h03,6'h05, 32'd7,  32'd9,   2'd1, 64'h28,       4'd5, 32'd7,   32'd9  },
    '{1'b0,1'b1,1'b0, 6'h00,6'h00, 32'd0,  32'd0,   2'd1, 64'h1,        4'd2, 32'd2,   32'd2  },
    '{1'b0,1'b0,1'b1, 6'h1C,6'h01, 32'd100,32'd200, 2'd2, {64{1'b1}},   4'd3, 32'd100, 32'd203},
    '{1'b0,1'b0,1'b1, 6'h02,6'h14, 32'd5,  32'd5,   2'd2, {64{1'b1}},   4'd2, 32'd7,   32'd5  },
    '{1'b1,1'b1,1'b1, 6'h03,6'h05, 32'd40, 32'd50,  2'd3, {64{1'b1}},   4'd4, 32'd40,  32'd50 },
    '{1'b1,1'b0,1'b0, 6'h14,6'h1C, 32'd0,  32'd0,   2'd0, 64'h1010_0000,4'd2, 32'd2,   32'd2  }
  };

  function automatic logic [63:0] mk(input logic ie, u, s, h,
                                     input logic [5:0] up, lo);
    return 64'(ie) | (64'(u) << 1) | (64'(s) << 2) | (64'(h) << 3)
         | (64'(lo) << 4) | (64'(up) << 11);
  endfunction

  task automatic check(input string req, input logic [63:0] got, exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic a, input logic [63:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] c;
    rst_n = 1'b0; evt_pulse = '0; ctx = 2'd3;
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_check("R1 ctrl", 1'b0, 64'h0);
    rd_check("R1 counters", 1'b1, 64'h0);
    check("R1 irq", 64'(irq), 64'h0);

    // R9 readback mask of configuration bits
    wr_reg(1'b0, {64{1'b1}});
    rd_check("R9 readback", 1'b0, 64'h1_FBFF);
    wr_reg(1'b0, 64'h0);

    // vector table: R2 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      wr_reg(1'b0, mk(1'b0, VECS[i].u, VECS[i].s, VECS[i].h, VECS[i].up, VECS[i].lo));
      wr_reg(1'b1, {VECS[i].pre_hi, VECS[i].pre_lo});
      ctx = VECS[i].cx;
      evt_pulse = VECS[i].mask;
      repeat (int'(VECS[i].n)) @(negedge clk);
      evt_pulse = '0;
      rd_check($sformatf("R2/R4/R5/R7 vector %0d", i), 1'b1,
               {VECS[i].exp_hi, VECS[i].exp_lo});
    end

    // R3 wrap of the upper counter, R6 interrupt
    c = mk(1'b1, 1'b1, 1'b0, 1'b0, 6'h03, 6'h05);
    wr_reg(1'b0, c);
    wr_reg(1'b1, {32'hFFFF_FFFF, 32'hFFFF_FFFE});
    ctx = 2'd0; evt_pulse = 64'h8;
    @(negedge clk);
    evt_pulse = '0;
    rd_check("R3 wrap value", 1'b1, {32'h0, 32'hFFFF_FFFE});
    rd_check("R3 upper flag", 1'b0, c | (64'd1 << 17));
    check("R6 irq on wrap", 64'(irq), 64'h1);

    // R6 gating by enable, R9 write-zero keeps flag
    wr_reg(1'b0, mk(1'b0, 1'b1, 1'b0, 1'b0, 6'h03, 6'h05));
    #1;
    check("R6 irq gated off", 64'(irq), 64'h0);
    rd_check("R9 flag kept on zero write", 1'b0,
             mk(1'b0, 1'b1, 1'b0, 1'b0, 6'h03, 6'h05) | (64'd1 << 17));
    wr_reg(1'b0, c);
    #1;
    check("R6 irq regated", 64'(irq), 64'h1);
    wr_reg(1'b0, c | (64'd1 << 17));
    #1;
    check("R9 clear irq", 64'(irq), 64'h0);
    rd_check("R9 clear flag", 1'b0, c);

    // R10 period arming on the lower counter
    wr_reg(1'b1, {32'h0, 32'hFFFF_FFFB});
    evt_pulse = 64'h20;
    repeat (4) @(negedge clk);
    evt_pulse = '0;
    #1;
    check("R10 no irq early", 64'(irq), 64'h0);
    rd_check("R10 count early", 1'b1, {32'h0, 32'hFFFF_FFFF});
    evt_pulse = 64'h20;
    @(negedge clk);
    evt_pulse = '0;
    #1;
    check("R10 irq at period", 64'(irq), 64'h1);
    rd_check("R10 lower flag", 1'b0, c | (64'd1 << 18));
    wr_reg(1'b0, c | (64'd1 << 18));

    // R8 write collides with events
    wr_reg(1'b1, 64'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = {32'h1234, 32'h55};
    evt_pulse = 64'h28;
    @(negedge clk);
    reg_wr = 1'b0; evt_pulse = '0;
    rd_check("R8 write wins", 1'b1, {32'h1234, 32'h55});

    // R9 wrap and clear in the same cycle: flag stays
    wr_reg(1'b1, {32'hFFFF_FFFF, 32'h0});
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = c | (64'd1 << 17);
    evt_pulse = 64'h8;
    @(negedge clk);
    reg_wr = 1'b0; evt_pulse = '0;
    #1;
    check("R9 set beats clear irq", 64'(irq), 64'h1);
    rd_check("R9 set beats clear flag", 1'b0, c | (64'd1 << 17));

    finish_run();
  end
endmodule